// File: doc/BRIEF.md
# GPIO Interrupt Sense and Pending Controller

This block turns 32 already-synchronized GPIO pin levels into interrupt requests. Every pin has its own 4-bit sense code that picks rising edge, falling edge, high level, low level or both-edge detection. A per-pin accept mask gates detection. A detected event sets a sticky pending bit. Software acknowledges a pending bit by writing a one to it. An enable mask, changed through separate set and clear strobes, selects which pending bits reach the two interrupt outputs. One output serves pins 0 to 15 and the other serves pins 16 to 31.

Software reaches all state through a simple word-addressed register port. Writes are one-cycle strobes (`req_i` with `we_i` high). Read data is combinational from `addr_i`. The address space has two windows, selected by address bit 6. The low window holds the control and status registers. The high window holds the four sense-code registers.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset the sense codes, accept mask, enable mask and pending vector are all 0, and both interrupt outputs are low.
- R2: The low three bits of a pin's sense code select its detection. Code 0 is a rising edge (previous cycle 0, now 1), 1 a falling edge, 2 a high level, 3 a low level and 4 either edge. Codes 5 to 7 never detect. Bit 3 is stored but does not change detection.
- R3: Pin n's sense code lives in the register at byte offset 0x40 + 4*(n/8), in bits 4*(n%8)+3 down to 4*(n%8). These registers read back what was written.
- R4: The accept mask at offset 0x14 is read/write. A pin whose accept bit is 0 can never set its pending bit.
- R5: Writing ones to offset 0x18 sets the matching enable bits, and writing ones to 0x1C clears them. Zero bits in either write leave the enable mask unchanged. Offset 0x18 reads back the enable mask.
- R6: Offset 0x20 reads the raw pending vector, independent of the enable mask.
- R7: Offset 0x24 reads the pending vector ANDed with the enable mask.
- R8: Writing ones to offset 0x28 clears the matching pending bits and leaves all other pending bits unchanged.
- R9: A level-sense pin whose level is still asserted stays pending after a clear write.
- R10: If a clear write and a new detection hit the same pin in the same cycle, the pending bit ends up set.
- R11: irq_o[0] is high exactly when any masked-status bit in 15:0 is set, and irq_o[1] when any bit in 31:16 is set. Both are updated in the same cycle as the pending and enable state.
- R12: Address bit 6 selects the sense window, where only offsets 0x40 to 0x4C are mapped. Writes to unmapped offsets in either window change no state. Reads of unmapped offsets, and of the write-only offsets 0x1C and 0x28, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 7 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | 32 | Synchronized pin levels |
| irq_o | output | 2 | Interrupt requests for the low and high pin halves |

## Verification
Several rules are checked by assertions on every cycle. A pin that is not accepted never raises its pending bit. A detection always leaves its pending bit set, even against a clear. A clear with no concurrent detection always drops the bit. Enable set and clear strobes take effect on the next edge, and a zero enable mask keeps both outputs low. Other behaviour can only be shown by the bench's scenarios, because it depends on the stimulus sequence. This covers which pin histories each sense code accepts, the position of a pin's field inside the sense registers, how level pins re-assert after acknowledgement, and the decoding of unmapped offsets in both windows.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int NP  = 32;          // pins
  localparam int AW  = 7;           // byte address width
  localparam int DW  = 32;          // data width
  localparam int FW  = 4;           // sense field width
  localparam int FPR = DW / FW;     // fields per sense register
  localparam int NSR = NP / FPR;    // sense registers
  localparam int SW  = $clog2(NSR);
  localparam int NIRQ = 2;

  typedef enum logic [2:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_e;

  localparam logic [AW-1:0] A_ACCEPT = 7'h14;
  localparam logic [AW-1:0] A_EN_SET = 7'h18;
  localparam logic [AW-1:0] A_EN_CLR = 7'h1C;
  localparam logic [AW-1:0] A_RAW    = 7'h20;
  localparam logic [AW-1:0] A_MSK    = 7'h24;
  localparam logic [AW-1:0] A_PCLR   = 7'h28;
endpackage

// File: rtl/gis_detect.sv
module gis_detect
  import gis_pkg::*;
#(
  parameter int N = NP
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          pin_i,
  input  logic [N-1:0]          accept_i,
  input  logic [N-1:0][FW-1:0]  sense_i,
  input  logic [N-1:0]          clr_i,
  output logic [N-1:0]          pend_o
);
  logic [N-1:0] prev_q, pend_q, hit;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic det;
    always_comb begin
      unique case (sense_i[g][2:0])
        SNS_RISE: det = pin_i[g] & ~prev_q[g];
        SNS_FALL: det = ~pin_i[g] & prev_q[g];
        SNS_HIGH: det = pin_i[g];
        SNS_LOW:  det = ~pin_i[g];
        SNS_BOTH: det = pin_i[g] ^ prev_q[g];
        default:  det = 1'b0;
      endcase
    end
    assign hit[g] = accept_i[g] & det;
  end

  // new detection dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= pin_i;
      pend_q <= (pend_q & ~clr_i) | hit;
    end
  end

  assign pend_o = pend_q;

  p_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(accept_i)) == '0));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(clr_i) & ~$past(hit)) == '0));
  p_hit_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gis_regs.sv
module gis_regs
  import gis_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [NP-1:0]          pend_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NP-1:0]          accept_o,
  output logic [NP-1:0]          en_o,
  output logic [NP-1:0][FW-1:0]  sense_o,
  output logic [NP-1:0]          pclr_o
);
  localparam int WA = AW - 2;

  logic [NP-1:0]         accept_q, en_q;
  logic [NP-1:0][FW-1:0] sense_q;
  logic                  wr, hi_win, sns_hit;
  logic [WA-1:0]         wa;
  logic [SW-1:0]         sidx;

  assign wr      = req_i & we_i;
  assign wa      = addr_i[AW-1:2];
  assign hi_win  = addr_i[AW-1];
  assign sns_hit = hi_win && (addr_i[AW-2:SW+2] == '0);
  assign sidx    = addr_i[SW+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= '0;
      en_q     <= '0;
      sense_q  <= '0;
    end else if (wr) begin
      if (!hi_win) begin
        if (wa == A_ACCEPT[AW-1:2]) accept_q <= wdata_i;
        if (wa == A_EN_SET[AW-1:2]) en_q     <= en_q | wdata_i;
        if (wa == A_EN_CLR[AW-1:2]) en_q     <= en_q & ~wdata_i;
      end else if (sns_hit) begin
        for (int f = 0; f < FPR; f++)
          sense_q[int'(sidx)*FPR + f] <= wdata_i[f*FW +: FW];
      end
    end
  end

  assign pclr_o = (wr && !hi_win && wa == A_PCLR[AW-1:2]) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (!hi_win) begin
      unique case (wa)
        A_ACCEPT[AW-1:2]: rdata_o = accept_q;
        A_EN_SET[AW-1:2]: rdata_o = en_q;
        A_RAW[AW-1:2]:    rdata_o = pend_i;
        A_MSK[AW-1:2]:    rdata_o = pend_i & en_q;
        default:          rdata_o = '0;
      endcase
    end else if (sns_hit) begin
      for (int f = 0; f < FPR; f++)
        rdata_o[f*FW +: FW] = sense_q[int'(sidx)*FPR + f];
    end
  end

  assign accept_o = accept_q;
  assign en_o     = en_q;
  assign sense_o  = sense_q;

  p_en_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !hi_win && wa == A_EN_SET[AW-1:2])
      |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
  p_en_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !hi_win && wa == A_EN_CLR[AW-1:2])
      |=> ((en_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gis_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NP-1:0]   pin_i,
  output logic [NIRQ-1:0] irq_o
);
  localparam int HALF = NP / NIRQ;

  logic [NP-1:0]         accept, en, pend, pclr, masked;
  logic [NP-1:0][FW-1:0] sense;

  gis_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .pend_i   (pend),
    .rdata_o  (rdata_o),
    .accept_o (accept),
    .en_o     (en),
    .sense_o  (sense),
    .pclr_o   (pclr)
  );

  gis_detect #(.N(NP)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pin_i),
    .accept_i (accept),
    .sense_i  (sense),
    .clr_i    (pclr),
    .pend_o   (pend)
  );

  assign masked = pend & en;

  for (genvar k = 0; k < NIRQ; k++) begin : g_irq
    assign irq_o[k] = |masked[k*HALF +: HALF];
  end

  p_irq_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> (irq_o == '0));
  p_irq_needs_pend_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> (irq_o == '0));
endmodule

// File: tb/gpio_irq_sense_bench.sv
`timescale 1ns/1ps
module gpio_irq_sense_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pins = '0;
  logic [1:0]  irq;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  gpio_irq_sense u_gpio_irq_sense (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .irq_o(irq)
  );

  // {sense code[3:0], level before, level after, expected pending}
  localparam int NV = 13;
  localparam logic [6:0] VEC [NV] = '{
    {4'h0, 1'b0, 1'b1, 1'b1}, {4'h0, 1'b1, 1'b0, 1'b0},
    {4'h1, 1'b1, 1'b0, 1'b1}, {4'h1, 1'b0, 1'b1, 1'b0},
    {4'h2, 1'b1, 1'b1, 1'b1}, {4'h2, 1'b0, 1'b0, 1'b0},
    {4'h3, 1'b0, 1'b0, 1'b1}, {4'h3, 1'b1, 1'b1, 1'b0},
    {4'h4, 1'b0, 1'b1, 1'b1}, {4'h4, 1'b1, 1'b0, 1'b1},
    {4'h4, 1'b1, 1'b1, 1'b0}, {4'h8, 1'b0, 1'b1, 1'b1},
    {4'h5, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(7'h20, d); chk("R1 raw", d, 0);
    rd(7'h40, d); chk("R1 sense", d, 0);
    rd(7'h14, d); chk("R1 accept", d, 0);
    rd(7'h18, d); chk("R1 enable", d, 0);
    chk("R1 irq", {30'd0, irq}, 0);

    // R2: table walk on pin 5 (register 0x40, bits 23:20)
    for (int i = 0; i < NV; i++) begin
      wr(7'h14, 0);
      pins = {26'd0, VEC[i][2], 5'd0};
      wr(7'h40, {8'd0, VEC[i][6:3], 20'd0});
      wr(7'h28, 32'hFFFF_FFFF);
      wr(7'h14, 32'h20);
      @(negedge clk);
      pins = {26'd0, VEC[i][1], 5'd0};
      @(negedge clk);
      rd(7'h20, d);
      chk($sformatf("R2 vec%0d", i), d, {26'd0, VEC[i][0], 5'd0});
    end

    // R3: pin 17 -> register 0x48, field 1
    wr(7'h14, 0);
    pins = 0;
    for (int k = 0; k < 4; k++) wr(7'h40 + 7'(4*k), 0);
    wr(7'h28, 32'hFFFF_FFFF);
    wr(7'h48, 32'h0000_0020);
    rd(7'h48, d); chk("R3 readback", d, 32'h20);
    wr(7'h14, 32'hFFFF_FFFF);
    rd(7'h14, d); chk("R4 accept rw", d, 32'hFFFF_FFFF);
    pins = 32'h0002_0000;
    @(negedge clk); @(negedge clk);
    rd(7'h20, d); chk("R3 pin17 only", d, 32'h0002_0000);

    // R5 R7 R11 R6
    wr(7'h18, 32'h0002_0000);
    rd(7'h18, d); chk("R5 set", d, 32'h0002_0000);
    rd(7'h24, d); chk("R7 masked", d, 32'h0002_0000);
    chk("R11 irq hi", {30'd0, irq}, 2'b10);
    wr(7'h1C, 32'h0002_0000);
    rd(7'h18, d); chk("R5 clear", d, 0);
    rd(7'h24, d); chk("R7 masked off", d, 0);
    rd(7'h20, d); chk("R6 raw unmasked", d, 32'h0002_0000);
    chk("R11 irq off", {30'd0, irq}, 2'b00);

    // R9: level still high survives clear
    wr(7'h28, 32'h0002_0000);
    rd(7'h20, d); chk("R9 level reassert", d, 32'h0002_0000);

    // R8, R11 low half: rising edge on pin 3
    @(negedge clk); pins[3] = 1;
    @(negedge clk);
    rd(7'h20, d); chk("R2 pin3 rise", d, 32'h0002_0008);
    wr(7'h18, 32'h8);
    chk("R11 irq lo", {30'd0, irq}, 2'b01);
    wr(7'h28, 32'h8);
    rd(7'h20, d); chk("R8 w1c", d, 32'h0002_0000);
    chk("R11 irq lo off", {30'd0, irq}, 2'b00);

    // R10: clear and new edge in same cycle
    @(negedge clk); pins[3] = 0;
    @(negedge clk);
    pins[3] = 1; req = 1; we = 1; addr = 7'h28; wdata = 32'h8;
    @(negedge clk);
    req = 0; we = 0;
    rd(7'h20, d); chk("R10 detect wins", d & 32'h8, 32'h8);

    // R4: accept off blocks detection
    wr(7'h14, 0);
    wr(7'h28, 32'hFFFF_FFFF);
    @(negedge clk); pins[3] = 0;
    @(negedge clk); pins[3] = 1;
    @(negedge clk); @(negedge clk);
    rd(7'h20, d); chk("R4 gated", d, 0);

    // R12: unmapped writes and reads
    wr(7'h08, 32'hFFFF_FFFF);
    wr(7'h50, 32'hFFFF_FFFF);
    wr(7'h00, 32'hFFFF_FFFF);
    rd(7'h48, d); chk("R12 sense kept", d, 32'h20);
    rd(7'h40, d); chk("R12 sense0 kept", d, 0);
    rd(7'h14, d); chk("R12 accept kept", d, 0);
    rd(7'h18, d); chk("R12 enable kept", d, 32'h8);
    rd(7'h50, d); chk("R12 hi unmapped", d, 0);
    rd(7'h08, d); chk("R12 lo unmapped", d, 0);
    rd(7'h1C, d); chk("R12 wo 1c", d, 0);
    rd(7'h28, d); chk("R12 wo 28", d, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule